// File: doc/BRIEF.md
# Descriptor-Chained Stream-to-Memory DMA Engine

This block is the receive half of a DMA channel. It takes a byte stream with a valid/ready handshake and an end-of-packet marker, and stores the bytes in memory buffers. The buffers are described by a linked list of data descriptors. Each descriptor is four words at consecutive word addresses: the next-descriptor address at offset 0, the buffer start at offset 1, the buffer end ("after", one past the last byte) at offset 2, and a flags word at offset 3. In the flags word, bit 0 marks end of list, bit 1 requests an interrupt and bit 2 records that a packet ended in this buffer.

A one-cycle `start` pulse launches the engine with the address of the first descriptor. The engine fetches the descriptor and fills its buffer until the buffer is full or a byte with end-of-packet arrives. It then writes back the real fill point and the packet-end flag, and raises interrupt requests toward the register block. After that it either moves on to the next descriptor or, on end of list, marks the context word disabled and stops. The channel stays stopped and refuses data until it is started again.

Top module: `sdma_in_engine`

## Requirements
- R1: After reset, `s_ready`, `busy`, `eol_flag`, `irq_set`, `wr_en` and `dsc_en` are all 0.
- R2: On `start` while idle, the engine reads four words from `first_desc`+0..3 (next, buf, after, flags). Flags bit 0 = end of list, bit 1 = interrupt request, bit 2 = packet ended here. `busy` stays 1 until the channel stops.
- R3: Each accepted byte (`s_valid` and `s_ready` both 1) is written at the current buffer pointer, and the pointer then increments. The first byte of a descriptor goes to its buf address.
- R4: A descriptor closes after the byte that brings the pointer to "after", or after a byte with `s_eop` = 1, whichever comes first. Bytes beyond that point are not written into that buffer.
- R5: On close, word offset 2 of the descriptor is rewritten with the pointer value. Word offset 3 is rewritten with its flags, with bit 2 set if the close was caused by end-of-packet.
- R6: The interrupt bits of a close are: bits 0 and 1 when the descriptor's flags bit 1 is set, and bit 3 when the close was caused by end-of-packet.
- R7: `irq_set` is a one-cycle pulse, given only when the close's bits OR'd into `raw_intr` change that value. `irq_bits` carries the bits in that cycle.
- R8: When a descriptor with end of list closes, the engine writes 1 (disable bit 0) to the word at `ctx_addr`, sets `eol_flag` and drops `busy`. A new `start` clears `eol_flag`.
- R9: While `eol_flag` is set, or while no buffer is being filled, `s_ready` is 0 and no byte is written.
- R10: When a descriptor without end of list closes, the engine fetches the descriptor at its next address and continues filling at that descriptor's buf address.
- R11: A descriptor whose buf equals its after accepts no byte. It closes at once, with its after field unchanged and no packet-end mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken while idle |
| first_desc | input | AW | Word address of the first descriptor |
| ctx_addr | input | AW | Word address of the context word to disable |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_eop | input | 1 | Byte is the last of a packet |
| s_ready | output | 1 | Engine takes the byte this cycle |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | AW | Byte write address |
| wr_data | output | 8 | Byte write data |
| dsc_en | output | 1 | Descriptor port access |
| dsc_we | output | 1 | Descriptor port write (else read) |
| dsc_addr | output | AW | Descriptor port word address |
| dsc_wdata | output | 32 | Descriptor port write data |
| dsc_rdata | input | 32 | Read data, one cycle after a read access |
| raw_intr | input | 4 | Current raw interrupt value of the register block |
| irq_set | output | 1 | One-cycle request to OR `irq_bits` into the raw value |
| irq_bits | output | 4 | Interrupt bits of the closing descriptor |
| eol_flag | output | 1 | Channel reached end of list |
| busy | output | 1 | Engine is not idle |

## Verification
The assertions assume that the descriptor port returns read data exactly one cycle after a read access. They also assume that no descriptor word sits at the context address, and that `raw_intr` changes only while no close is in progress. The bench memory model gives the one-cycle read latency. The bench places descriptors and the context word in separate regions, and it changes `raw_intr` only while the engine is idle. Sweeps over buffer sizes 0 to 3 and packet lengths 1 to 4 cover both kinds of close.

// File: rtl/sdma_in_pkg.sv
package sdma_in_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned DESC_WORDS = 4;
    localparam int unsigned INTR_W     = 4;

    // word offsets inside one descriptor
    localparam int unsigned OFS_NEXT  = 0;
    localparam int unsigned OFS_BUF   = 1;
    localparam int unsigned OFS_AFTER = 2;
    localparam int unsigned OFS_FLAGS = 3;

    // flag bit positions
    localparam int unsigned FLG_EOL   = 0;
    localparam int unsigned FLG_INTR  = 1;
    localparam int unsigned FLG_INEOP = 2;

    localparam logic [WORD_W-1:0] CTX_DISABLED = WORD_W'(1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RECV,
        ST_CLOSE,
        ST_WB,
        ST_CTX
    } state_e;

    typedef struct packed {
        logic [WORD_W-1:0] next;
        logic [WORD_W-1:0] buf_ptr;
        logic [WORD_W-1:0] after;
        logic [WORD_W-1:0] flags;
    } desc_t;

    // interrupt bits produced by one descriptor close
    function automatic logic [INTR_W-1:0] close_bits(input logic want_intr,
                                                     input logic by_eop);
        return {by_eop, 1'b0, want_intr, want_intr};
    endfunction

endpackage

// File: rtl/sdma_in_byteio.sv
module sdma_in_byteio #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          en,
    input  logic [AW-1:0] limit,
    input  logic          s_valid,
    input  logic [7:0]    s_data,
    input  logic          s_eop,
    output logic          s_ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          close_now,
    output logic          close_eop,
    output logic [AW-1:0] ptr
);

    logic          accept;
    logic [AW-1:0] ptr_inc;

    assign accept    = s_valid && en;
    assign ptr_inc   = ptr + AW'(1);
    assign s_ready   = en;
    assign wr_en     = accept;
    assign wr_addr   = ptr;
    assign wr_data   = s_data;
    assign close_now = accept && ((ptr_inc == limit) || s_eop);
    assign close_eop = s_eop;

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (accept)
            ptr <= ptr_inc;
    end

endmodule

// File: rtl/sdma_in_irq.sv
module sdma_in_irq
    import sdma_in_pkg::*;
(
    input  logic              fire,
    input  logic              want_intr,
    input  logic              by_eop,
    input  logic [INTR_W-1:0] raw_intr,
    output logic              irq_set,
    output logic [INTR_W-1:0] irq_bits
);

    assign irq_bits = close_bits(want_intr, by_eop);
    assign irq_set  = fire && ((raw_intr | irq_bits) != raw_intr);

endmodule

// File: rtl/sdma_in_engine.sv
module sdma_in_engine
    import sdma_in_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     first_desc,
    input  logic [AW-1:0]     ctx_addr,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_eop,
    output logic              s_ready,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [7:0]        wr_data,
    output logic              dsc_en,
    output logic              dsc_we,
    output logic [AW-1:0]     dsc_addr,
    output logic [WORD_W-1:0] dsc_wdata,
    input  logic [WORD_W-1:0] dsc_rdata,
    input  logic [INTR_W-1:0] raw_intr,
    output logic              irq_set,
    output logic [INTR_W-1:0] irq_bits,
    output logic              eol_flag,
    output logic              busy
);

    localparam int unsigned CW = $clog2(DESC_WORDS + 1);

    state_e        state;
    logic [CW-1:0] cnt;
    logic [AW-1:0] cur;
    desc_t         dsc;
    logic          eop_hit;

    logic          ptr_load;
    logic          close_now;
    logic          close_eop;
    logic [AW-1:0] ptr;
    logic          fetch_done;

    assign fetch_done = (state == ST_FETCH) && (cnt == CW'(DESC_WORDS));
    assign ptr_load   = fetch_done;
    assign busy       = (state != ST_IDLE);

    sdma_in_byteio #(.AW(AW)) u_byteio (
        .clk       (clk),
        .rst       (rst),
        .load      (ptr_load),
        .load_val  (dsc.buf_ptr[AW-1:0]),
        .en        ((state == ST_RECV) && !eol_flag),
        .limit     (dsc.after[AW-1:0]),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_eop     (s_eop),
        .s_ready   (s_ready),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .close_now (close_now),
        .close_eop (close_eop),
        .ptr       (ptr)
    );

    sdma_in_irq u_irq (
        .fire      (state == ST_CLOSE),
        .want_intr (dsc.flags[FLG_INTR]),
        .by_eop    (eop_hit),
        .raw_intr  (raw_intr),
        .irq_set   (irq_set),
        .irq_bits  (irq_bits)
    );

    // descriptor port drive
    always_comb begin
        dsc_en    = 1'b0;
        dsc_we    = 1'b0;
        dsc_addr  = cur;
        dsc_wdata = '0;
        unique case (state)
            ST_FETCH: begin
                dsc_en   = (cnt < CW'(DESC_WORDS));
                dsc_addr = cur + AW'(cnt);
            end
            ST_WB: begin
                dsc_en    = 1'b1;
                dsc_we    = 1'b1;
                dsc_addr  = (cnt == '0) ? cur + AW'(OFS_AFTER) : cur + AW'(OFS_FLAGS);
                dsc_wdata = (cnt == '0) ? dsc.after : dsc.flags;
            end
            ST_CTX: begin
                dsc_en    = 1'b1;
                dsc_we    = 1'b1;
                dsc_addr  = ctx_addr;
                dsc_wdata = CTX_DISABLED;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cur      <= '0;
            dsc      <= '0;
            eop_hit  <= 1'b0;
            eol_flag <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur      <= first_desc;
                        cnt      <= '0;
                        eol_flag <= 1'b0;
                        state    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    cnt <= cnt + CW'(1);
                    if (cnt != '0) begin
                        unique case (cnt - CW'(1))
                            CW'(OFS_NEXT):  dsc.next    <= dsc_rdata;
                            CW'(OFS_BUF):   dsc.buf_ptr <= dsc_rdata;
                            CW'(OFS_AFTER): dsc.after   <= dsc_rdata;
                            default:        dsc.flags   <= dsc_rdata;
                        endcase
                    end
                    if (fetch_done) begin
                        eop_hit <= 1'b0;
                        state   <= (dsc.buf_ptr[AW-1:0] == dsc.after[AW-1:0])
                                   ? ST_CLOSE : ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (close_now) begin
                        eop_hit <= close_eop;
                        state   <= ST_CLOSE;
                    end
                end
                ST_CLOSE: begin
                    dsc.after <= WORD_W'(ptr);
                    if (eop_hit)
                        dsc.flags[FLG_INEOP] <= 1'b1;
                    cnt   <= '0;
                    state <= ST_WB;
                end
                ST_WB: begin
                    cnt <= cnt + CW'(1);
                    if (cnt != '0) begin
                        cnt <= '0;
                        if (dsc.flags[FLG_EOL]) begin
                            state <= ST_CTX;
                        end else begin
                            cur   <= dsc.next[AW-1:0];
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_CTX: begin
                    eol_flag <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdma_in_engine_chk.sv
module sdma_in_engine_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          s_valid,
    input logic          s_ready,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          dsc_en,
    input logic          dsc_we,
    input logic [AW-1:0] dsc_addr,
    input logic [31:0]   dsc_wdata,
    input logic [AW-1:0] ctx_addr,
    input logic [3:0]    raw_intr,
    input logic          irq_set,
    input logic [3:0]    irq_bits,
    input logic          eol_flag,
    input logic          busy
);

    AST_EOL_NO_READY: assert property (@(posedge clk) disable iff (rst)
        eol_flag |-> !s_ready); // R9

    AST_WR_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (s_valid && s_ready)); // R3

    AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + AW'(1))); // R3

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> !irq_set); // R7

    AST_IRQ_ADDS_BITS: assert property (@(posedge clk) disable iff (rst)
        irq_set |-> ((irq_bits & ~raw_intr) != 4'b0)); // R7

    AST_CTX_DISABLE: assert property (@(posedge clk) disable iff (rst)
        (dsc_en && dsc_we && dsc_addr == ctx_addr) |-> dsc_wdata[0]); // R8

    AST_EOL_STOPPED: assert property (@(posedge clk) disable iff (rst)
        $rose(eol_flag) |-> !busy); // R8

endmodule

bind sdma_in_engine sdma_in_engine_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .dsc_en    (dsc_en),
    .dsc_we    (dsc_we),
    .dsc_addr  (dsc_addr),
    .dsc_wdata (dsc_wdata),
    .ctx_addr  (ctx_addr),
    .raw_intr  (raw_intr),
    .irq_set   (irq_set),
    .irq_bits  (irq_bits),
    .eol_flag  (eol_flag),
    .busy      (busy)
);

// File: tb/sdma_in_engine_test.sv
`timescale 1ns/1ps
module sdma_in_engine_test;

    localparam int AW = 16;
    localparam logic [AW-1:0] CTX = 16'h00F0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] first_desc = '0;
    logic          s_valid = 1'b0;
    logic [7:0]    s_data = '0;
    logic          s_eop = 1'b0;
    logic          s_ready;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          dsc_en, dsc_we;
    logic [AW-1:0] dsc_addr;
    logic [31:0]   dsc_wdata;
    logic [31:0]   dsc_rdata = '0;
    logic [3:0]    raw_intr = '0;
    logic          irq_set;
    logic [3:0]    irq_bits;
    logic          eol_flag, busy;

    logic [31:0]   dmem [0:255];
    logic [7:0]    bmem [0:255];
    logic          h_we = 1'b0;
    logic [7:0]    h_addr = '0;
    logic [31:0]   h_data = '0;
    int            wr_total = 0;
    int            pulse_total = 0;
    logic [3:0]    last_bits = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdma_in_engine #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .start(start), .first_desc(first_desc),
        .ctx_addr(CTX), .s_valid(s_valid), .s_data(s_data), .s_eop(s_eop),
        .s_ready(s_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dsc_en(dsc_en), .dsc_we(dsc_we), .dsc_addr(dsc_addr),
        .dsc_wdata(dsc_wdata), .dsc_rdata(dsc_rdata), .raw_intr(raw_intr),
        .irq_set(irq_set), .irq_bits(irq_bits), .eol_flag(eol_flag), .busy(busy)
    );

    // memory model: one-cycle read latency, host port for setup
    always @(posedge clk) begin
        if (h_we)
            dmem[h_addr] <= h_data;
        else if (dsc_en && dsc_we)
            dmem[dsc_addr[7:0]] <= dsc_wdata;
        if (dsc_en && !dsc_we)
            dsc_rdata <= dmem[dsc_addr[7:0]];
        if (wr_en) begin
            bmem[wr_addr[7:0]] <= wr_data;
            wr_total <= wr_total + 1;
        end
        if (irq_set) begin
            pulse_total <= pulse_total + 1;
            last_bits   <= irq_bits;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        h_we = 1'b1; h_addr = a; h_data = d;
    endtask

    task automatic hw_end();
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic put_desc(input logic [7:0] at, input logic [31:0] nx,
                            input logic [31:0] bp, input logic [31:0] af,
                            input logic [31:0] fl);
        hw(at, nx); hw(at + 8'd1, bp); hw(at + 8'd2, af); hw(at + 8'd3, fl);
    endtask

    task automatic kick(input logic [AW-1:0] d);
        @(negedge clk);
        start = 1'b1; first_desc = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    // send n bytes, values base+i; returns how many were taken
    task automatic send(input int n, input bit eop_last, input logic [7:0] base,
                        output int taken);
        taken = 0;
        for (int i = 0; i < n; i++) begin
            int k;
            @(negedge clk);
            s_valid = 1'b1; s_data = base + 8'(i);
            s_eop = eop_last && (i == n - 1);
            k = 0;
            while (!s_ready && k < 40) begin
                @(negedge clk);
                k++;
            end
            if (!s_ready) break;
            @(posedge clk);
            taken++;
        end
        @(negedge clk);
        s_valid = 1'b0; s_eop = 1'b0;
    endtask

    task automatic wait_idle();
        int k;
        k = 0;
        @(negedge clk);
        while (busy && k < 200) begin
            @(negedge clk);
            k++;
        end
    endtask

    // one end-of-list descriptor of size sz, packet of pk bytes
    task automatic run_single(input int sz, input int pk, input bit intr,
                              input logic [3:0] raw, input logic [7:0] base);
        int taken, fill, w0, p0;
        bit eop;
        logic [31:0] fl, bytes_ok, exp_flags;
        logic [3:0]  bits;
        bit          exp_pulse;
        fill = (pk < sz) ? pk : sz;
        eop  = (pk <= sz);
        fl   = 32'(1) | (intr ? 32'(2) : 32'(0));
        put_desc(8'h80, 32'h0, 32'h60, 32'h60 + 32'(sz), fl);
        hw(CTX[7:0], 32'h0);
        hw_end();
        raw_intr = raw;
        w0 = wr_total; p0 = pulse_total;
        kick(16'h0080);
        check(eol_flag == 1'b0, "R8 start clears eol", 32'(eol_flag), 0);
        send(pk, 1'b1, base, taken);
        wait_idle();
        check(taken == fill, (sz == 0) ? "R11 empty takes nothing" : "R4 bytes taken",
              32'(taken), 32'(fill));
        check(wr_total - w0 == fill, "R3 write count", 32'(wr_total - w0), 32'(fill));
        bytes_ok = 1;
        for (int i = 0; i < fill; i++)
            if (bmem[8'h60 + 8'(i)] !== base + 8'(i)) bytes_ok = 0;
        check(bytes_ok == 1, "R3 byte contents", bytes_ok, 1);
        check(dmem[8'h82] == 32'h60 + 32'(fill), "R5 after rewritten",
              dmem[8'h82], 32'h60 + 32'(fill));
        exp_flags = fl | (eop ? 32'h4 : 32'h0);
        check(dmem[8'h83] == exp_flags, "R5 flags written back", dmem[8'h83], exp_flags);
        check(dmem[CTX[7:0]] == 32'h1, "R8 context disabled", dmem[CTX[7:0]], 1);
        check(eol_flag && !busy, "R8 stopped at end of list", {eol_flag, busy}, 2'b10);
        bits = {eop, 1'b0, intr, intr};
        exp_pulse = ((raw | bits) != raw);
        check((pulse_total - p0) == int'(exp_pulse), "R7 pulse only on change",
              32'(pulse_total - p0), 32'(exp_pulse));
        if (exp_pulse)
            check(last_bits == bits, "R6 interrupt bits", 32'(last_bits), 32'(bits));
        raw_intr = 4'h0;
    endtask

    initial begin
        int taken, p0;
        repeat (3) @(negedge clk);
        check(!s_ready && !busy && !eol_flag && !irq_set && !wr_en && !dsc_en,
              "R1 reset outputs", {s_ready, busy, eol_flag, irq_set, wr_en, dsc_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!s_ready && !busy, "R9 idle refuses", {s_ready, busy}, 0);

        // chain: A fills, B ends by packet, C empty with end of list
        put_desc(8'h40, 32'h48, 32'h10, 32'h13, 32'h0);
        put_desc(8'h48, 32'h50, 32'h20, 32'h24, 32'h2);
        put_desc(8'h50, 32'h0,  32'h30, 32'h30, 32'h1);
        hw(CTX[7:0], 32'h0);
        hw_end();
        p0 = pulse_total;
        kick(16'h0040);
        check(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
        send(3, 1'b0, 8'hA0, taken);
        check(taken == 3, "R4 fill closes A", 32'(taken), 3);
        send(2, 1'b1, 8'hB0, taken);
        check(taken == 2, "R10 next descriptor takes packet", 32'(taken), 2);
        wait_idle();
        check(bmem[8'h10] == 8'hA0 && bmem[8'h12] == 8'hA2, "R3 A bytes",
              {bmem[8'h10], bmem[8'h12]}, 16'hA0A2);
        check(bmem[8'h20] == 8'hB0 && bmem[8'h21] == 8'hB1, "R10 B bytes at buf",
              {bmem[8'h20], bmem[8'h21]}, 16'hB0B1);
        check(dmem[8'h42] == 32'h13 && dmem[8'h43] == 32'h0, "R5 A writeback",
              dmem[8'h43], 0);
        check(dmem[8'h4A] == 32'h22, "R5 B after shortened", dmem[8'h4A], 32'h22);
        check(dmem[8'h4B] == 32'h6, "R5 B in_eop marked", dmem[8'h4B], 32'h6);
        check(dmem[8'h52] == 32'h30 && dmem[8'h53] == 32'h1, "R11 empty C unchanged",
              dmem[8'h53], 1);
        check(pulse_total - p0 == 1, "R7 one pulse on chain", 32'(pulse_total - p0), 1);
        check(last_bits == 4'hB, "R6 intr plus eop bits", 32'(last_bits), 32'hB);
        check(eol_flag && dmem[CTX[7:0]] == 32'h1, "R8 chain end", dmem[CTX[7:0]], 1);
        @(negedge clk);
        s_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(!s_ready && !wr_en, "R9 refuses after end of list", {s_ready, wr_en}, 0);
        s_valid = 1'b0;

        // sweep sizes and packet lengths
        for (int sz = 0; sz < 4; sz++)
            for (int pk = 1; pk < 5; pk++)
                run_single(sz, pk, 1'b1, 4'h0, 8'(sz * 16 + pk * 4));
        run_single(2, 1, 1'b0, 4'h0, 8'h70);  // eop only: bit 3
        run_single(2, 1, 1'b1, 4'hB, 8'h74);  // nothing new: no pulse
        run_single(3, 5, 1'b1, 4'h3, 8'h78);  // bits already raised: no pulse
        run_single(2, 2, 1'b1, 4'h3, 8'h7C);  // bit 3 new: pulse

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule